// File: doc/BRIEF.md
# CRC4 Errored-Submultiframe Resync Monitor

This block sits behind the CRC4 checker of an E1 receive framer. Once the receiver holds multiframe alignment, it takes one result per checked submultiframe and counts the errored results over a sliding block of fixed length. If too many of those results are errored, the current frame alignment is taken to be false. The block then raises a one-cycle request that makes the framer restart both the doubleframe and the multiframe search. The framer places the restarted search just after the last basic frame alignment word it accepted.

Counting runs only while the receiver is in multiframe sync and doubleframe sync. When doubleframe alignment drops, both counts freeze. When multiframe alignment is regained, the counts used to decide on resync start again from zero. A second errored-submultiframe counter gives a saturating count for performance monitoring. Software clears it with a clear-on-read strobe.

Top module: `crc4_resync_mon`

## Requirements
- R1: After reset, `resync_req` is 0 and `pm_count` is 0.
- R2: A qualified result is a cycle with `crc_valid`=1, `mf_sync`=1 and `df_sync`=1. An errored result also has `crc_err`=1. When a qualified errored result brings the block's error count to THRESH (default 915) and `auto_resync_en`=1, `resync_req` is 1 in the next cycle only.
- R3: Each qualified result advances the block position by one. After WIN (default 1000) qualified results with no request, the position and the error count both restart. A request also restarts both counts.
- R4: While `auto_resync_en`=0, `resync_req` stays 0. The counts still advance and restart at the end of each block.
- R5: While `mf_sync`=0, `crc_valid` has no effect on either counter.
- R6: While `df_sync`=0, both counters hold their values. They are not cleared, and counting resumes from those values once `df_sync` returns to 1.
- R7: In the cycle after `mf_sync` rises, the block position and the error count are zero. A result in the cycle of the rise counts as the first result of a new block.
- R8: `pm_count` adds one for each qualified errored result. It holds at 2^PM_W-1.
- R9: One cycle after `pm_clear`=1, `pm_count` is 0. It is 1 instead if a qualified errored result arrived in the same cycle as the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| crc_valid | input | 1 | One-cycle strobe: a submultiframe CRC check result is present |
| crc_err | input | 1 | With `crc_valid`: the submultiframe failed its CRC check |
| mf_sync | input | 1 | Receiver holds multiframe alignment |
| df_sync | input | 1 | Receiver holds doubleframe alignment |
| auto_resync_en | input | 1 | Enables the automatic resync request |
| pm_clear | input | 1 | Clear-on-read strobe for `pm_count` |
| resync_req | output | 1 | One-cycle request to restart the doubleframe and multiframe search |
| pm_count | output | PM_W | Saturating count of errored submultiframes |

## Verification
Some properties are checked on every cycle. The request lasts exactly one cycle. It only follows a qualified errored result, and it never appears while the enable is low. The monitoring count holds while sync is absent, stays at its ceiling, and lands at 0 or 1 after a clear. The bench scenarios cover what needs a long history. These include the exact threshold of 915 errors within the 1000-result block, near misses that straddle the block boundary, and several requests in a row. They also cover the difference between freezing during doubleframe loss and clearing when multiframe sync is regained.

// File: rtl/crc4rs_pkg.sv
// Shared types and helpers for the CRC4 resync monitor.
// Assumes: counts are unsigned and never exceed the parameters they are sized from.
package crc4rs_pkg;

    // One qualified CRC result as seen by the counting logic.
    typedef struct packed {
        logic counted;   // result is inside the synchronous state
        logic errored;   // result carried a CRC mismatch
    } crc_evt_t;

    // Bits needed to hold the values 0..n.
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/crc4rs_qualify.sv
// Turns the raw CRC strobe into a counted event and spots the regain of multiframe sync.
// Assumes: mf_sync and df_sync are already synchronous to clk.
module crc4rs_qualify
    import crc4rs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     crc_valid,
    input  logic     crc_err,
    input  logic     mf_sync,
    input  logic     df_sync,
    output crc_evt_t evt,
    output logic     mf_regain
);

    logic mf_q;

    // Remembers last cycle's multiframe sync flag for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) mf_q <= 1'b0;
        else        mf_q <= mf_sync;
    end

    // Counts only while both alignment levels are held; the rise of mf_sync marks a regain.
    always_comb begin
        evt.counted = crc_valid && mf_sync && df_sync;
        evt.errored = crc_valid && mf_sync && df_sync && crc_err;
        mf_regain   = mf_sync && !mf_q;
    end

endmodule

// File: rtl/crc4rs_window.sv
// Block counter and error counter that decide on false alignment.
// Assumes: 2 <= THRESH <= WIN, and events arrive at most once per cycle.
module crc4rs_window
    import crc4rs_pkg::*;
#(
    parameter int WIN    = 1000,
    parameter int THRESH = 915
) (
    input  logic     clk,
    input  logic     rst_n,
    input  crc_evt_t evt,
    input  logic     mf_regain,
    input  logic     auto_en,
    output logic     resync_req
);

    localparam int             CW       = cnt_w(WIN);
    localparam logic [CW-1:0]  POS_LAST = CW'(WIN - 1);
    localparam logic [CW-1:0]  ERR_TRIP = CW'(THRESH - 1);

    logic [CW-1:0] pos_q, err_q;
    logic [CW-1:0] pos_base, err_base;
    logic [CW-1:0] pos_d, err_d;
    logic          fire;

    // Next-state logic: a regain clears first, then the current result is applied.
    always_comb begin
        pos_base = mf_regain ? '0 : pos_q;
        err_base = mf_regain ? '0 : err_q;
        pos_d    = pos_base;
        err_d    = err_base;
        fire     = 1'b0;
        if (evt.counted) begin
            fire = auto_en && evt.errored && (err_base == ERR_TRIP);
            if (fire || (pos_base == POS_LAST)) begin
                pos_d = '0;
                err_d = '0;
            end else begin
                pos_d = pos_base + 1'b1;
                err_d = err_base + CW'(evt.errored);
            end
        end
    end

    // Holds the block position and error count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            err_q <= '0;
        end else begin
            pos_q <= pos_d;
            err_q <= err_d;
        end
    end

    // Registers the one-cycle resync request.
    always_ff @(posedge clk) begin
        if (!rst_n) resync_req <= 1'b0;
        else        resync_req <= fire;
    end

endmodule

// File: rtl/crc4rs_pm_ctr.sv
// Saturating errored-submultiframe counter for performance readout.
// Assumes: pm_clear is a single-cycle read strobe; an event in the clear cycle is kept.
module crc4rs_pm_ctr
    import crc4rs_pkg::*;
#(
    parameter int PM_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  crc_evt_t        evt,
    input  logic            pm_clear,
    output logic [PM_W-1:0] pm_count
);

    localparam logic [PM_W-1:0] PM_MAX = {PM_W{1'b1}};

    logic [PM_W-1:0] base, nxt;

    // Clear first, then add the current errored result unless already at the ceiling.
    always_comb begin
        base = pm_clear ? '0 : pm_count;
        nxt  = base;
        if (evt.errored && (base != PM_MAX)) nxt = base + 1'b1;
    end

    // Holds the monitoring count.
    always_ff @(posedge clk) begin
        if (!rst_n) pm_count <= '0;
        else        pm_count <= nxt;
    end

endmodule

// File: rtl/crc4_resync_mon.sv
// Top of the CRC4 errored-submultiframe resync monitor.
// Assumes: the framer acts on resync_req and restarts its own search; CRC is computed upstream.
module crc4_resync_mon
    import crc4rs_pkg::*;
#(
    parameter int WIN    = 1000,
    parameter int THRESH = 915,
    parameter int PM_W   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            crc_valid,
    input  logic            crc_err,
    input  logic            mf_sync,
    input  logic            df_sync,
    input  logic            auto_resync_en,
    input  logic            pm_clear,
    output logic            resync_req,
    output logic [PM_W-1:0] pm_count
);

    crc_evt_t evt;
    logic     mf_regain;

    crc4rs_qualify u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .crc_valid (crc_valid),
        .crc_err   (crc_err),
        .mf_sync   (mf_sync),
        .df_sync   (df_sync),
        .evt       (evt),
        .mf_regain (mf_regain)
    );

    crc4rs_window #(.WIN(WIN), .THRESH(THRESH)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .mf_regain  (mf_regain),
        .auto_en    (auto_resync_en),
        .resync_req (resync_req)
    );

    crc4rs_pm_ctr #(.PM_W(PM_W)) u_pm (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .pm_clear (pm_clear),
        .pm_count (pm_count)
    );

endmodule

// File: rtl/crc4_resync_mon_chk.sv
// Port-level checker for crc4_resync_mon, attached with bind.
// Assumes: inputs are driven to known values from time zero.
module crc4_resync_mon_chk #(
    parameter int PM_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            crc_valid,
    input logic            crc_err,
    input logic            mf_sync,
    input logic            df_sync,
    input logic            auto_resync_en,
    input logic            pm_clear,
    input logic            resync_req,
    input logic [PM_W-1:0] pm_count
);

    p_req_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        resync_req |=> !resync_req);

    p_req_from_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        resync_req |-> $past(crc_valid && crc_err && mf_sync && df_sync));

    p_req_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        resync_req |-> $past(auto_resync_en));

    p_pm_hold_nomf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mf_sync && !pm_clear) |=> $stable(pm_count));

    p_pm_hold_dfasync_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!df_sync && !pm_clear) |=> $stable(pm_count));

    p_pm_saturate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((&pm_count) && !pm_clear) |=> (&pm_count));

    p_pm_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pm_clear |=> (pm_count <= PM_W'(1)));

endmodule

bind crc4_resync_mon crc4_resync_mon_chk #(.PM_W(PM_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .crc_valid      (crc_valid),
    .crc_err        (crc_err),
    .mf_sync        (mf_sync),
    .df_sync        (df_sync),
    .auto_resync_en (auto_resync_en),
    .pm_clear       (pm_clear),
    .resync_req     (resync_req),
    .pm_count       (pm_count)
);

// File: tb/crc4_resync_mon_test.sv
// Self-checking bench: table of scenarios, then directed corner cases.
module crc4_resync_mon_test;

    localparam int PM_W = 10;
    localparam int PM_MAX = (1 << PM_W) - 1;

    typedef struct packed {
        logic [11:0] n_ok;
        logic [11:0] n_err;
        logic        mf;
        logic        df;
        logic        en;
        logic [3:0]  exp_req;
        logic [10:0] exp_pm;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{12'd0,  12'd915,  1'b1, 1'b1, 1'b1, 4'd1, 11'd915},
        '{12'd0,  12'd914,  1'b1, 1'b1, 1'b1, 4'd0, 11'd914},
        '{12'd0,  12'd915,  1'b1, 1'b1, 1'b0, 4'd0, 11'd915},
        '{12'd0,  12'd915,  1'b1, 1'b0, 1'b1, 4'd0, 11'd0},
        '{12'd0,  12'd915,  1'b0, 1'b1, 1'b1, 4'd0, 11'd0},
        '{12'd85, 12'd915,  1'b1, 1'b1, 1'b1, 4'd1, 11'd915},
        '{12'd86, 12'd915,  1'b1, 1'b1, 1'b1, 4'd0, 11'd915},
        '{12'd0,  12'd1830, 1'b1, 1'b1, 1'b1, 4'd2, 11'd1023},
        '{12'd0,  12'd1100, 1'b1, 1'b1, 1'b0, 4'd0, 11'd1023}
    };
    // R2 exact hit, R2 near miss, R4 disabled, R6 df lost, R5 mf lost,
    // R3 hit on last slot, R3 straddle, R8 repeat + saturation, R8 saturation
    localparam string VTAG [NV] = '{"R2", "R2", "R4", "R6", "R5", "R3", "R3", "R8", "R8"};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            crc_valid = 1'b0;
    logic            crc_err = 1'b0;
    logic            mf_sync = 1'b0;
    logic            df_sync = 1'b0;
    logic            auto_resync_en = 1'b0;
    logic            pm_clear = 1'b0;
    logic            resync_req;
    logic [PM_W-1:0] pm_count;

    int n_chk = 0;
    int n_fail = 0;
    int req_seen = 0;

    always #10 clk = ~clk;

    crc4_resync_mon #(.PM_W(PM_W)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .crc_valid      (crc_valid),
        .crc_err        (crc_err),
        .mf_sync        (mf_sync),
        .df_sync        (df_sync),
        .auto_resync_en (auto_resync_en),
        .pm_clear       (pm_clear),
        .resync_req     (resync_req),
        .pm_count       (pm_count)
    );

    // Counts request pulses, sampled away from the active edge.
    always @(negedge clk) if (rst_n && resync_req) req_seen <= req_seen + 1;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic mf, input logic df, input logic en);
        rst_n = 1'b0;
        crc_valid = 1'b0;
        crc_err = 1'b0;
        pm_clear = 1'b0;
        mf_sync = mf;
        df_sync = df;
        auto_resync_en = en;
        repeat (2) @(negedge clk);
        req_seen = 0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic strobe(input logic err, input int n);
        for (int i = 0; i < n; i++) begin
            crc_valid = 1'b1;
            crc_err = err;
            @(negedge clk);
        end
        crc_valid = 1'b0;
        crc_err = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset(1'b1, 1'b1, 1'b1);
        chk("R1", int'(resync_req), 0);
        chk("R1", int'(pm_count), 0);

        // Table walk: each row from reset
        for (int v = 0; v < NV; v++) begin
            do_reset(VECS[v].mf, VECS[v].df, VECS[v].en);
            strobe(1'b0, int'(VECS[v].n_ok));
            strobe(1'b1, int'(VECS[v].n_err));
            repeat (3) @(negedge clk);
            chk(VTAG[v], req_seen, int'(VECS[v].exp_req));
            chk("R8", int'(pm_count), int'(VECS[v].exp_pm));
        end

        // R2: request appears exactly one cycle after the 915th error
        do_reset(1'b1, 1'b1, 1'b1);
        strobe(1'b1, 914);
        chk("R2", int'(resync_req), 0);
        strobe(1'b1, 1);
        chk("R2", int'(resync_req), 1);
        @(negedge clk);
        chk("R2", int'(resync_req), 0);

        // R6: doubleframe loss freezes but keeps the counts
        do_reset(1'b1, 1'b1, 1'b1);
        strobe(1'b1, 900);
        df_sync = 1'b0;
        strobe(1'b1, 100);
        chk("R6", int'(pm_count), 900);
        df_sync = 1'b1;
        @(negedge clk);
        strobe(1'b1, 15);
        repeat (2) @(negedge clk);
        chk("R6", req_seen, 1);

        // R5 and R7: results ignored without multiframe sync; regain clears
        do_reset(1'b1, 1'b1, 1'b1);
        strobe(1'b1, 900);
        mf_sync = 1'b0;
        @(negedge clk);
        strobe(1'b1, 50);
        chk("R5", int'(pm_count), 900);
        mf_sync = 1'b1;
        @(negedge clk);
        strobe(1'b1, 15);
        repeat (2) @(negedge clk);
        chk("R7", req_seen, 0);
        strobe(1'b1, 900);
        repeat (2) @(negedge clk);
        chk("R7", req_seen, 1);

        // R9: clear alone, then clear with a same-cycle errored result
        pm_clear = 1'b1;
        @(negedge clk);
        pm_clear = 1'b0;
        chk("R9", int'(pm_count), 0);
        strobe(1'b1, 3);
        chk("R9", int'(pm_count), 3);
        pm_clear = 1'b1;
        crc_valid = 1'b1;
        crc_err = 1'b1;
        @(negedge clk);
        pm_clear = 1'b0;
        crc_valid = 1'b0;
        crc_err = 1'b0;
        chk("R9", int'(pm_count), 1);

        // R8: good results do not add to the monitoring count
        strobe(1'b0, 20);
        chk("R8", int'(pm_count), 1);

        chk("R8", PM_MAX, 1023);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule